// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the single-cycle arithmetic and logic stage of a small 8-bit RISC core. Each cycle it takes a register operand, a second operand, the current status flags and a 5-bit operation select. The second operand is either a register or an immediate field of the instruction. From these it returns an 8-bit result, a result-writeback enable, the next value of all six status flags and a per-flag write mask. Every operation owns a fixed subset of the flags. The flags it does not own leave the block exactly as they came in, so the core can write `flags_out` back under `flags_we` without any merging of its own.

The carry-in comes from the incoming status (bit 0). The zero flag coming in (bit 1) serves the chained subtract and compare forms, which let multi-byte comparisons finish in a single zero test. Next to the datapath, a small branch evaluator picks one status condition and tests it for set or clear. It drives the taken signal for conditional branches, including the signed and unsigned orderings.

The block is purely combinational. It has no clock and no reset, and it holds no state.

Status flag positions, used by every port that carries flags: bit 0 C (carry/borrow), bit 1 Z (zero), bit 2 N (negative), bit 3 V (overflow), bit 4 S (sign, N xor V), bit 5 H (half carry).

Top module: `alu8_core`

## Requirements
- R1: For codes 0 (add), 1 (add with carry), 2 (subtract), 3 (subtract with carry) and 4 (negate, 0 minus op_a), the result is the 8-bit sum or difference and the mask is 6'b111111. Code 1 adds C and code 3 subtracts C. C is the carry out or the borrow. H is the carry out of bit 3 or the borrow into bit 4. V is two's-complement overflow, and S = N xor V. Z is set for a zero result, except as R2 says.
- R2: For codes 3 and 6, Z becomes 1 only when the result is zero and the incoming Z is 1. A nonzero result clears Z.
- R3: Codes 5 (compare) and 6 (compare with carry) produce the flags of codes 2 and 3 with the same mask, and drive res_we to 0.
- R4: Codes 7 (AND), 8 (OR) and 9 (XOR) write Z, N, V and S with V = 0 (mask 6'b011110). C and H pass through unchanged.
- R5: Codes 11 (increment) and 12 (decrement) write only Z, N, V and S. V is set exactly when the operand is 0x7F for code 11, or 0x80 for code 12. C and H pass through.
- R6: Code 10 (complement) gives 0xFF minus op_a and sets C = 1 and V = 0 (mask 6'b011111). H is unchanged.
- R7: Shifts use mask 6'b011111, set C to the bit shifted out, and set V = N xor C after the shift. The codes are:
  - 13: left, 0 in.
  - 14: right, 0 in.
  - 15: left with C into bit 0.
  - 16: right with C into bit 7.
  - 17: arithmetic right, bit 7 kept.
- R8: Code 18 exchanges the two nibbles of op_a and writes no flag. flags_out equals status_in.
- R9: With use_imm = 1, op_imm takes the place of op_b in every operation that uses a second operand.
- R10: br_taken = flag xor cond_clr. The flag is picked by cond_sel: 0 C, 1 Z, 2 N, 3 V, 5 H, 4 the live N xor V, and 6 and 7 a constant 1. This gives the following branches:
  - Signed greater-or-equal: cond_sel 4 with cond_clr 1.
  - Signed less-than: cond_sel 4 with cond_clr 0.
  - Unsigned same-or-higher: cond_sel 0 with cond_clr 1.
  - Unsigned lower: cond_sel 0 with cond_clr 0.
- R11: Codes 19 to 31 return op_a with res_we = 0 and flags_we = 0.
- R12: Every flag bit whose flags_we bit is 0 leaves on flags_out equal to status_in. res_we is 1 for all codes 0 to 18 other than 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand (destination register) |
| op_b | input | 8 | Second operand from a register |
| op_imm | input | 8 | Second operand from an immediate field |
| use_imm | input | 1 | Selects op_imm as the second operand |
| op_sel | input | 5 | Operation code |
| status_in | input | 6 | Current flags {H,S,V,N,Z,C} |
| cond_sel | input | 3 | Branch condition select |
| cond_clr | input | 1 | 1: branch when condition clear; 0: when set |
| result | output | 8 | Operation result |
| res_we | output | 1 | Result writeback enable |
| flags_out | output | 6 | Next flags {H,S,V,N,Z,C} |
| flags_we | output | 6 | Per-flag write mask |
| br_taken | output | 1 | Branch condition outcome |

## Verification
The hardest case to reach is the chained zero flag. The incoming Z must matter only for codes 3 and 6, and only when the result is zero. A random operand pair almost never produces a zero difference, and it has to do so while the incoming Z is clear.

The stimulus sweeps every operation code against an operand list. That list includes equal pairs and the 0x00/0x7F/0x80/0xFF boundaries, so each zero difference is met with both Z polarities and both carry-in values. The status patterns 000000, 111111, 101010 and 010101 also put every untouched flag into both states. This exposes any operation that disturbs a flag outside its mask.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int FLAG_W = 6;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;

    localparam logic [FLAG_W-1:0] MASK_ALL  = 6'b111111;
    localparam logic [FLAG_W-1:0] MASK_ZCNV = 6'b011111;
    localparam logic [FLAG_W-1:0] MASK_ZNV  = 6'b011110;
    localparam logic [FLAG_W-1:0] MASK_NONE = 6'b000000;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADC   = 5'd1,
        OP_SUB   = 5'd2,
        OP_SBC   = 5'd3,
        OP_NEG   = 5'd4,
        OP_CMP   = 5'd5,
        OP_CMPC  = 5'd6,
        OP_AND   = 5'd7,
        OP_OR    = 5'd8,
        OP_XOR   = 5'd9,
        OP_INV   = 5'd10,
        OP_INC   = 5'd11,
        OP_DEC   = 5'd12,
        OP_SHL   = 5'd13,
        OP_SHR   = 5'd14,
        OP_RLC   = 5'd15,
        OP_RRC   = 5'd16,
        OP_SAR   = 5'd17,
        OP_NSWAP = 5'd18
    } alu_op_e;

    typedef enum logic [2:0] {
        CS_C   = 3'd0,
        CS_Z   = 3'd1,
        CS_N   = 3'd2,
        CS_V   = 3'd3,
        CS_NXV = 3'd4,
        CS_H   = 3'd5,
        CS_ON6 = 3'd6,
        CS_ON7 = 3'd7
    } cond_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half,
    output logic         ovf
);
    localparam int HW = W / 2;

    logic [W:0]  full;
    logic [HW:0] low;

    always_comb begin
        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
            low  = {1'b0, x[HW-1:0]} - {1'b0, y[HW-1:0]} - {{HW{1'b0}}, cin};
            ovf  = (x[W-1] & ~y[W-1] & ~full[W-1]) | (~x[W-1] & y[W-1] & full[W-1]);
        end else begin
            full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
            low  = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + {{HW{1'b0}}, cin};
            ovf  = (x[W-1] & y[W-1] & ~full[W-1]) | (~x[W-1] & ~y[W-1] & full[W-1]);
        end
        sum  = full[W-1:0];
        cout = full[W];
        half = low[HW];
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int HW = W / 2;

    always_comb begin
        res  = a;
        cout = 1'b0;
        case (op)
            OP_AND:   res = a & b;
            OP_OR:    res = a | b;
            OP_XOR:   res = a ^ b;
            OP_INV: begin
                res  = ~a;
                cout = 1'b1;
            end
            OP_SHL: begin
                res  = {a[W-2:0], 1'b0};
                cout = a[W-1];
            end
            OP_RLC: begin
                res  = {a[W-2:0], cin};
                cout = a[W-1];
            end
            OP_SHR: begin
                res  = {1'b0, a[W-1:1]};
                cout = a[0];
            end
            OP_RRC: begin
                res  = {cin, a[W-1:1]};
                cout = a[0];
            end
            OP_SAR: begin
                res  = {a[W-1], a[W-1:1]};
                cout = a[0];
            end
            OP_NSWAP: res = {a[HW-1:0], a[W-1:HW]};
            default: begin
                res  = a;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu8_branch.sv
module alu8_branch
    import alu8_pkg::*;
#(
    parameter int FW = 6
) (
    input  logic [FW-1:0] status,
    input  logic [2:0]    sel,
    input  logic          clr,
    output logic          taken
);
    logic flag;

    always_comb begin
        unique case (cond_sel_e'(sel))
            CS_C:   flag = status[FL_C];
            CS_Z:   flag = status[FL_Z];
            CS_N:   flag = status[FL_N];
            CS_V:   flag = status[FL_V];
            CS_NXV: flag = status[FL_N] ^ status[FL_V];
            CS_H:   flag = status[FL_H];
            CS_ON6: flag = 1'b1;
            CS_ON7: flag = 1'b1;
        endcase
        taken = flag ^ clr;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] op_a,
    input  logic [7:0] op_b,
    input  logic [7:0] op_imm,
    input  logic       use_imm,
    input  logic [4:0] op_sel,
    input  logic [5:0] status_in,
    input  logic [2:0] cond_sel,
    input  logic       cond_clr,
    output logic [7:0] result,
    output logic       res_we,
    output logic [5:0] flags_out,
    output logic [5:0] flags_we,
    output logic       br_taken
);
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] ZERO = '0;

    alu_op_e            op;
    logic [DATA_W-1:0]  b_eff;

    logic [DATA_W-1:0]  as_x, as_y;
    logic               as_cin, as_sub;
    logic [DATA_W-1:0]  as_sum;
    logic               as_c, as_h, as_v;

    logic [DATA_W-1:0]  bo_res;
    logic               bo_c;

    logic               use_arith, is_shift, z_chain;
    logic [FLAG_W-1:0]  mask;
    logic [FLAG_W-1:0]  fresh;
    logic               wb;
    logic [DATA_W-1:0]  r;
    logic               c_n, z_n, n_n, v_n;

    assign op    = alu_op_e'(op_sel);
    assign b_eff = use_imm ? op_imm : op_b;

    // Operand routing and flag ownership per operation
    always_comb begin
        as_x      = op_a;
        as_y      = b_eff;
        as_cin    = 1'b0;
        as_sub    = 1'b0;
        use_arith = 1'b0;
        is_shift  = 1'b0;
        z_chain   = 1'b0;
        wb        = 1'b1;
        mask      = MASK_NONE;
        case (op)
            OP_ADD: begin
                use_arith = 1'b1;
                mask      = MASK_ALL;
            end
            OP_ADC: begin
                use_arith = 1'b1;
                as_cin    = status_in[FL_C];
                mask      = MASK_ALL;
            end
            OP_SUB, OP_CMP: begin
                use_arith = 1'b1;
                as_sub    = 1'b1;
                mask      = MASK_ALL;
                wb        = (op == OP_SUB);
            end
            OP_SBC, OP_CMPC: begin
                use_arith = 1'b1;
                as_sub    = 1'b1;
                as_cin    = status_in[FL_C];
                z_chain   = 1'b1;
                mask      = MASK_ALL;
                wb        = (op == OP_SBC);
            end
            OP_NEG: begin
                use_arith = 1'b1;
                as_sub    = 1'b1;
                as_x      = ZERO;
                as_y      = op_a;
                mask      = MASK_ALL;
            end
            OP_INC: begin
                use_arith = 1'b1;
                as_y      = ONE;
                mask      = MASK_ZNV;
            end
            OP_DEC: begin
                use_arith = 1'b1;
                as_sub    = 1'b1;
                as_y      = ONE;
                mask      = MASK_ZNV;
            end
            OP_AND, OP_OR, OP_XOR: mask = MASK_ZNV;
            OP_INV:                mask = MASK_ZCNV;
            OP_SHL, OP_SHR, OP_RLC, OP_RRC, OP_SAR: begin
                is_shift = 1'b1;
                mask     = MASK_ZCNV;
            end
            OP_NSWAP: mask = MASK_NONE;
            default: begin
                wb   = 1'b0;
                mask = MASK_NONE;
            end
        endcase
    end

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .x    (as_x),
        .y    (as_y),
        .cin  (as_cin),
        .sub  (as_sub),
        .sum  (as_sum),
        .cout (as_c),
        .half (as_h),
        .ovf  (as_v)
    );

    alu8_bitops #(.W(DATA_W)) u_bitops (
        .a    (op_a),
        .b    (b_eff),
        .cin  (status_in[FL_C]),
        .op   (op),
        .res  (bo_res),
        .cout (bo_c)
    );

    alu8_branch #(.FW(FLAG_W)) u_branch (
        .status (status_in),
        .sel    (cond_sel),
        .clr    (cond_clr),
        .taken  (br_taken)
    );

    // Flag formation and merge with the untouched flags
    always_comb begin
        r   = use_arith ? as_sum : bo_res;
        c_n = use_arith ? as_c : bo_c;
        n_n = r[DATA_W-1];
        z_n = (r == ZERO) & (~z_chain | status_in[FL_Z]);
        if (use_arith)     v_n = as_v;
        else if (is_shift) v_n = n_n ^ c_n;
        else               v_n = 1'b0;
        fresh        = '0;
        fresh[FL_C]  = c_n;
        fresh[FL_Z]  = z_n;
        fresh[FL_N]  = n_n;
        fresh[FL_V]  = v_n;
        fresh[FL_S]  = n_n ^ v_n;
        fresh[FL_H]  = as_h;
        result    = r;
        res_we    = wb;
        flags_we  = mask;
        flags_out = (fresh & mask) | (status_in & ~mask);
    end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
    input logic [7:0] op_a,
    input logic [4:0] op_sel,
    input logic [5:0] status_in,
    input logic [7:0] result,
    input logic       res_we,
    input logic [5:0] flags_out,
    input logic [5:0] flags_we
);
    always_comb begin
        if (flags_we[2])
            assert_sign_is_nxv_R1: assert (flags_out[4] == (flags_out[2] ^ flags_out[3]))
                else $error("S differs from N xor V");
        if ((op_sel == 5'd3 || op_sel == 5'd6) && !status_in[1])
            assert_zero_chain_R2: assert (!flags_out[1])
                else $error("chained Z set with incoming Z clear");
        if (op_sel == 5'd5 || op_sel == 5'd6)
            assert_compare_no_wb_R3: assert (!res_we)
                else $error("compare wrote back");
        if (op_sel >= 5'd7 && op_sel <= 5'd9)
            assert_logic_keeps_ch_R4: assert (!flags_we[0] && !flags_we[5] && !flags_out[3]
                                              && flags_out[0] == status_in[0]
                                              && flags_out[5] == status_in[5])
                else $error("logic op touched C/H or set V");
        if (op_sel == 5'd10)
            assert_invert_carry_R6: assert (flags_out[0] && !flags_out[3])
                else $error("complement flags wrong");
        if (op_sel == 5'd18)
            assert_swap_silent_R8: assert (flags_we == 6'b0 && flags_out == status_in)
                else $error("nibble swap wrote flags");
        if (op_sel >= 5'd19)
            assert_undef_inert_R11: assert (!res_we && flags_we == 6'b0 && result == op_a)
                else $error("undefined code had an effect");
    end
endmodule

bind alu8_core alu8_core_chk u_chk (.*);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [7:0] op_a, op_b, op_imm;
    logic       use_imm;
    logic [4:0] op_sel;
    logic [5:0] status_in;
    logic [2:0] cond_sel;
    logic       cond_clr;
    logic [7:0] result;
    logic       res_we;
    logic [5:0] flags_out, flags_we;
    logic       br_taken;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core u0 (
        .op_a(op_a), .op_b(op_b), .op_imm(op_imm), .use_imm(use_imm),
        .op_sel(op_sel), .status_in(status_in), .cond_sel(cond_sel),
        .cond_clr(cond_clr), .result(result), .res_we(res_we),
        .flags_out(flags_out), .flags_we(flags_we), .br_taken(br_taken)
    );

    function automatic int pick(input int i);
        case (i)
            0: return 8'h00;  1: return 8'hFF;  2: return 8'h7F;  3: return 8'h80;
            4: return 8'h0F;  5: return 8'hF0;  6: return 8'h01;  7: return 8'h08;
            default: return (i * 37 + 11) & 255;
        endcase
    endfunction

    function automatic int sx(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic string tag_of(input int op);
        if (op == 3)  return "R1/R2";
        if (op <= 4)  return "R1";
        if (op <= 6)  return "R3/R2";
        if (op <= 9)  return "R4";
        if (op == 10) return "R6";
        if (op <= 12) return "R5";
        if (op <= 17) return "R7";
        if (op == 18) return "R8";
        return "R11";
    endfunction

    // Reference from the requirements; unwritten bits pass through (R12)
    task automatic model(input int op, input int a, input int b, input logic [5:0] st,
                         output int r, output bit we, output logic [5:0] fo,
                         output logic [5:0] fw);
        int  ci, t, sv;
        bit  c, h, v, z, n, arith;
        logic [5:0] nf;
        ci = int'(st[0]);
        c = 0; h = 0; v = 0; arith = 0;
        we = (op <= 18) && op != 5 && op != 6;
        r  = a;
        fw = 6'b000000;
        case (op)
            0, 1: begin
                t  = a + b + ((op == 1) ? ci : 0);
                r  = t & 255; c = (t > 255);
                h  = ((a & 15) + (b & 15) + ((op == 1) ? ci : 0)) > 15;
                sv = sx(a) + sx(b) + ((op == 1) ? ci : 0);
                v  = (sv > 127) || (sv < -128); fw = 6'b111111; arith = 1;
            end
            2, 3, 5, 6, 4: begin
                int xa, yb, k;
                xa = (op == 4) ? 0 : a;
                yb = (op == 4) ? a : b;
                k  = (op == 3 || op == 6) ? ci : 0;
                t  = xa - yb - k;
                r  = t & 255; c = (t < 0);
                h  = ((xa & 15) - (yb & 15) - k) < 0;
                sv = sx(xa) - sx(yb) - k;
                v  = (sv > 127) || (sv < -128); fw = 6'b111111; arith = 1;
            end
            7:  begin r = a & b; fw = 6'b011110; end
            8:  begin r = a | b; fw = 6'b011110; end
            9:  begin r = a ^ b; fw = 6'b011110; end
            10: begin r = 255 - a; c = 1; fw = 6'b011111; end
            11: begin r = (a + 1) & 255; v = (a == 127); fw = 6'b011110; end
            12: begin r = (a + 255) & 255; v = (a == 128); fw = 6'b011110; end
            13: begin r = (a * 2) & 255;      c = (a >= 128); fw = 6'b011111; end
            14: begin r = a / 2;              c = a[0];       fw = 6'b011111; end
            15: begin r = (a * 2 + ci) & 255; c = (a >= 128); fw = 6'b011111; end
            16: begin r = a / 2 + ci * 128;   c = a[0];       fw = 6'b011111; end
            17: begin r = a / 2 + (a & 128);  c = a[0];       fw = 6'b011111; end
            18: r = ((a & 15) * 16) + (a / 16);
            default: r = a;
        endcase
        n = (r >= 128);
        z = (r == 0);
        if (op == 3 || op == 6) z = z && st[1];   // R2: zero chaining
        if (op >= 13 && op <= 17) v = n ^ c;
        nf = {h, n ^ v, v, n, z, c};
        if (!arith) nf[5] = 1'b0;
        fo = (nf & fw) | (st & ~fw);
    endtask

    initial begin
        logic [5:0] pats [4];
        pats[0] = 6'b000000; pats[1] = 6'b111111; pats[2] = 6'b101010; pats[3] = 6'b010101;
        cond_sel = 3'd0; cond_clr = 1'b0;
        #(CLK_PERIOD/4);
        for (int op = 0; op < 32; op++) begin
            for (int ia = 0; ia < 32; ia++) begin
                for (int ib = 0; ib < 32; ib++) begin
                    for (int p = 0; p < 4; p++) begin
                        int er; bit ew; logic [5:0] efo, efw; int bv;
                        bv = (ib == 31) ? pick(ia) : pick(ib);  // equal pair: zero difference
                        op_sel    = 5'(op);
                        op_a      = 8'(pick(ia));
                        status_in = pats[p];
                        use_imm   = (ia + ib + p) % 2 == 1;     // R9: immediate path
                        if (use_imm) begin op_imm = 8'(bv); op_b = ~8'(bv); end
                        else         begin op_b = 8'(bv);   op_imm = ~8'(bv); end
                        #2;
                        model(op, pick(ia), bv, pats[p], er, ew, efo, efw);
                        n_vec++;
                        if (result !== 8'(er) || res_we !== ew || flags_out !== efo
                            || flags_we !== efw) begin
                            n_fail++;
                            $display("FAIL %s%s R12 op=%0d a=%02h b=%02h st=%b imm=%0b: got r=%02h we=%0b f=%b m=%b exp r=%02h we=%0b f=%b m=%b",
                                     tag_of(op), use_imm ? "/R9" : "", op, pick(ia), bv,
                                     pats[p], use_imm, result, res_we, flags_out, flags_we,
                                     8'(er), ew, efo, efw);
                        end
                    end
                end
            end
        end
        // R10: branch condition evaluator over every status pattern
        op_sel = 5'd18;
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 2; k++) begin
                for (int st = 0; st < 64; st++) begin
                    logic [5:0] sb; bit f, exp_t;
                    sb = 6'(st);
                    cond_sel = 3'(s); cond_clr = k[0]; status_in = sb;
                    #2;
                    case (s)
                        0: f = sb[0]; 1: f = sb[1]; 2: f = sb[2]; 3: f = sb[3];
                        4: f = sb[2] ^ sb[3]; 5: f = sb[5];
                        default: f = 1'b1;
                    endcase
                    exp_t = (k == 1) ? !f : f;
                    n_vec++;
                    if (br_taken !== exp_t) begin
                        n_fail++;
                        $display("FAIL R10 sel=%0d clr=%0d st=%b: got %0b exp %0b",
                                 s, k, sb, br_taken, exp_t);
                    end
                end
            end
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule